// File: doc/BRIEF.md
# Bit-Reversed Counter PWM DAC

This block produces a single pulse-width modulated output meant to feed an external RC low-pass filter, giving a simple digital-to-analog converter. A free-running N-bit count advances on clocks where an internal programmable prescaler issues an enable pulse. The registered output is high while the latched duty code is larger than the count. In the default mode, the count's bits are mirrored before the comparison.

Mirroring the count spreads the high clocks of each period across the whole period. It does not gather them into one block. The average duty is unchanged, but the pulse rate is much higher, so the external filter can be smaller or give less ripple. The mirroring is only wiring. A mode input selects plain comparison, so both waveforms can be compared side by side.

A new duty code takes effect only at the start of a period. No period ever mixes two codes.

Top module: `bitrev_pwm_dac`

## Requirements
- R1: A synchronous active-high `rst` clears the count, the prescaler, the latched duty and `pwm_out`. While `rst` is high, `pwm_out` is 0.
- R2: The count advances by one, modulo 2^N, on each clock where the prescaler enable is high. It holds otherwise. One output period is 2^N enables.
- R3: The prescaler issues one enable every `presc_tc`+1 clocks. A `presc_tc` of 0 gives an enable on every clock. There are never two enables on consecutive clocks unless `presc_tc` is 0.
- R4: With `mode_in`=0 (mirrored mode), count bit i feeds comparator bit N-1-i. `pwm_out` is registered: after each clock edge it is 1 exactly when the latched duty was strictly greater than the mirrored count before that edge.
- R5: With `mode_in`=1 (plain mode), `pwm_out` after each edge is 1 exactly when the latched duty was strictly greater than the plain count before that edge.
- R6: In either mode, each full period holds exactly as many high enable-steps as the duty code. Code 0 never drives the output high, and code 2^N-1 gives 2^N-1 high steps.
- R7: `duty_in` is latched only on the enable that moves the count from all ones to zero. The first period after reset therefore runs with duty 0.
- R8: With N=4, mirrored mode and duty 8, the output alternates high and low on every enable step, starting high at count 0.
- R9: With duty 1, the mirrored and plain modes give the same output sequence: a single high step at count 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| duty_in | input | N | Duty code, latched at period start |
| mode_in | input | 1 | 0: mirrored comparison, 1: plain comparison |
| presc_tc | input | PW | Prescaler terminal count; enable every presc_tc+1 clocks |
| pwm_out | output | 1 | Registered PWM output |

## Verification
The assertions watch a small set of invariants on every cycle:
- the count jumps to zero after a wrap and holds when no enable arrives;
- the prescaler never enables twice in a row while its terminal count is non-zero;
- the latched duty holds between wraps;
- a zero duty code keeps the output low.

Other properties are whole-period or whole-sequence facts that the bench scenarios must show:
- the per-period high count;
- the alternating pattern at half scale;
- the equality of the two modes at code 1;
- the three-clock hold under a divided enable;
- the all-low first period after reset.

A behavioural model compared on every clock covers all inputs together.

// File: rtl/bitrev_pwm_pkg.sv
package bitrev_pwm_pkg;

    typedef enum logic {
        CMP_MIRRORED = 1'b0,
        CMP_PLAIN    = 1'b1
    } cmp_mode_e;

    typedef struct packed {
        logic advance;
        logic wrap;
    } step_evt_t;

endpackage

// File: rtl/bitrev_pwm_prescaler.sv
module bitrev_pwm_prescaler #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] tc,
    output logic          tick
);
    logic [PW-1:0] div_q;

    assign tick = (div_q >= tc);

    always_ff @(posedge clk) begin
        if (rst)       div_q <= '0;
        else if (tick) div_q <= '0;
        else           div_q <= div_q + PW'(1);
    end

    // R3: with a non-zero stable terminal count, enables are never adjacent
    a_r3_no_adjacent_tick: assert property (@(posedge clk) disable iff (rst)
        (tick && tc != '0) |=> (!tick || !$stable(tc)));

endmodule

// File: rtl/bitrev_pwm_counter.sv
module bitrev_pwm_counter
    import bitrev_pwm_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    output logic [N-1:0] cnt,
    output step_evt_t    evt
);
    logic [N-1:0] cnt_q;

    assign cnt         = cnt_q;
    assign evt.advance = en;
    assign evt.wrap    = en && (cnt_q == '1);

    always_ff @(posedge clk) begin
        if (rst)     cnt_q <= '0;
        else if (en) cnt_q <= cnt_q + N'(1);
    end

    // R2: a wrap lands on zero
    a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
        evt.wrap |=> (cnt_q == '0));

    // R2: no enable, no movement
    a_r2_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(cnt_q));

endmodule

// File: rtl/bitrev_pwm_compare.sv
module bitrev_pwm_compare
    import bitrev_pwm_pkg::*;
#(
    parameter int N = 8
) (
    input  cmp_mode_e    mode,
    input  logic [N-1:0] cnt,
    input  logic [N-1:0] duty,
    output logic         hit
);
    logic [N-1:0] mirrored;
    logic [N-1:0] operand;

    for (genvar i = 0; i < N; i++) begin : g_mirror
        assign mirrored[i] = cnt[N-1-i];
    end

    always_comb begin
        operand = (mode == CMP_PLAIN) ? cnt : mirrored;
        hit     = (duty > operand);
    end

endmodule

// File: rtl/bitrev_pwm_dac.sv
module bitrev_pwm_dac
    import bitrev_pwm_pkg::*;
#(
    parameter int N  = 8,
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  duty_in,
    input  logic          mode_in,
    input  logic [PW-1:0] presc_tc,
    output logic          pwm_out
);
    logic         step_en;
    logic [N-1:0] count;
    step_evt_t    evt;
    logic [N-1:0] duty_q;
    logic         hit;
    logic         out_q;

    bitrev_pwm_prescaler #(.PW(PW)) u_presc (
        .clk  (clk),
        .rst  (rst),
        .tc   (presc_tc),
        .tick (step_en)
    );

    bitrev_pwm_counter #(.N(N)) u_count (
        .clk (clk),
        .rst (rst),
        .en  (step_en),
        .cnt (count),
        .evt (evt)
    );

    bitrev_pwm_compare #(.N(N)) u_cmp (
        .mode (cmp_mode_e'(mode_in)),
        .cnt  (count),
        .duty (duty_q),
        .hit  (hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            duty_q <= '0;
            out_q  <= 1'b0;
        end else begin
            if (evt.wrap) duty_q <= duty_in;
            out_q <= hit;
        end
    end

    assign pwm_out = out_q;

    // R7: the latched code moves only at a period boundary
    a_r7_duty_hold: assert property (@(posedge clk) disable iff (rst)
        !evt.wrap |=> $stable(duty_q));

    // R6: a zero code never produces a high step
    a_r6_zero_low: assert property (@(posedge clk) disable iff (rst)
        (duty_q == '0) |=> !pwm_out);

endmodule

// File: tb/sim_bitrev_pwm_dac.sv
module sim_bitrev_pwm_dac;
    localparam int N   = 4;
    localparam int PW  = 4;
    localparam int MAX = (1 << N) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  duty_in = '0;
    logic          mode_in = 1'b0;
    logic [PW-1:0] presc_tc = '0;
    logic          pwm_out;

    int checks = 0;
    int fails  = 0;
    bit armed  = 0;
    bit seq [0:63];
    int skip_hi;

    int m_pre = 0, m_cnt = 0, m_duty = 0, m_out = 0;

    always #4 clk = ~clk;

    bitrev_pwm_dac #(.N(N), .PW(PW)) u0 (
        .clk(clk), .rst(rst), .duty_in(duty_in), .mode_in(mode_in),
        .presc_tc(presc_tc), .pwm_out(pwm_out)
    );

    function automatic int mirror(input int v);
        int r = 0;
        for (int i = 0; i < N; i++) if (v[i]) r |= (1 << (N - 1 - i));
        return r;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference model (R1-R7)
    always @(posedge clk) begin
        int sel, nxt;
        bit tick;
        if (rst) begin
            m_pre = 0; m_cnt = 0; m_duty = 0; m_out = 0;
        end else begin
            tick  = (m_pre >= int'(presc_tc));
            sel   = mode_in ? m_cnt : mirror(m_cnt);
            m_out = (m_duty > sel) ? 1 : 0;
            if (tick) begin
                if (m_cnt == MAX) m_duty = int'(duty_in);
                nxt   = (m_cnt + 1) % (MAX + 1);
                m_cnt = nxt;
                m_pre = 0;
            end else begin
                m_pre = m_pre + 1;
            end
        end
    end

    always @(negedge clk) begin
        if (armed) check("R4/R5 model compare", int'(pwm_out), m_out);
    end

    task automatic run_window(input int d, input int m, input int tc,
                              input int skip, input int len);
        duty_in = N'(d); mode_in = m[0]; presc_tc = PW'(tc);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 reset output low", int'(pwm_out), 0);
        rst = 1'b0;
        skip_hi = 0;
        repeat (skip) begin
            @(negedge clk);
            skip_hi += int'(pwm_out);
        end
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            seq[i] = pwm_out;
        end
    endtask

    function automatic int ones(input int len);
        int c = 0;
        for (int i = 0; i < len; i++) c += int'(seq[i]);
        return c;
    endfunction

    function automatic int mask16();
        int v = 0;
        for (int i = 0; i < 16; i++) if (seq[i]) v |= (1 << i);
        return v;
    endfunction

    initial begin
        int bad, m_a, m_b;
        armed = 0;
        repeat (2) @(negedge clk);
        armed = 1;

        // R8 alternating at half scale, R7 first period low
        run_window(8, 0, 0, 16, 16);
        check("R7 first period uses duty 0", skip_hi, 0);
        bad = 0;
        for (int i = 0; i < 16; i++) if (int'(seq[i]) != ((i % 2 == 0) ? 1 : 0)) bad++;
        check("R8 alternating pattern mismatches", bad, 0);
        check("R6 duty 8 mirrored high count", ones(16), 8);

        // R5 plain half scale: contiguous block
        run_window(8, 1, 0, 16, 16);
        bad = 0;
        for (int i = 0; i < 16; i++) if (int'(seq[i]) != ((i < 8) ? 1 : 0)) bad++;
        check("R5 plain contiguous mismatches", bad, 0);
        check("R6 duty 8 plain high count", ones(16), 8);

        // R9 code 1 equal in both modes
        run_window(1, 0, 0, 16, 16);
        m_a = mask16();
        run_window(1, 1, 0, 16, 16);
        m_b = mask16();
        check("R9 mirrored vs plain at code 1", m_a, m_b);
        check("R9 single high at count 0", m_a, 1);

        // R6 extremes
        run_window(0, 0, 0, 16, 16);
        check("R6 code 0 high count", ones(16), 0);
        run_window(MAX, 0, 0, 16, 16);
        check("R6 full code mirrored high count", ones(16), MAX);
        check("R7 first period low with full code", skip_hi, 0);
        run_window(5, 0, 0, 16, 16);
        check("R6 code 5 mirrored high count", ones(16), 5);
        run_window(5, 1, 0, 16, 16);
        check("R6 code 5 plain high count", ones(16), 5);

        // R2/R3 prescaler terminal count 2: each step lasts 3 clocks
        run_window(8, 0, 2, 48, 48);
        bad = 0;
        for (int i = 0; i < 48; i++) if (int'(seq[i]) != (((i / 3) % 2 == 0) ? 1 : 0)) bad++;
        check("R3 divided enable hold mismatches", bad, 0);
        check("R2 one period over 48 clocks high count", ones(48), 24);

        // R7 mid-period change waits for the wrap
        run_window(8, 0, 0, 16, 8);
        duty_in = N'(2);
        for (int i = 8; i < 16; i++) begin
            @(negedge clk);
            seq[i] = pwm_out;
        end
        check("R7 mid-period change ignored", ones(16), 8);
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            seq[i] = pwm_out;
        end
        check("R7 new code after wrap", ones(16), 2);

        armed = 0;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 8);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule